// File: doc/BRIEF.md
# Processor Status Word Register Unit

This block holds the 128-bit processor status word of a CPU. The word can be loaded from a compact 64-bit image or a full 128-bit image. Before it accepts an image, the block checks the format marker, the addressing-mode pair and the bits that must be zero. A compact image is expanded into the 128-bit layout as it is written. A rejected image leaves the register as it was and raises an error pulse.

While instructions run, the execution pipeline writes the condition code and the instruction address through separate update ports. A branch unit presents a 4-bit mask and gets back a taken flag, which is computed against the stored condition code. The whole word is always visible on an output so that an extract operation can read it.

Bit numbering is big-endian: bit 0 is the most significant bit of every image and of the stored word.

Top module: `psw_unit`

## Requirements
- R1: After reset, `psw_o` is all zero and `fmt_err_o` is 0.
- R2: A 128-bit load (`load_long_i`=1) that passes the format checks is stored unchanged, except that its address field is masked as described in R5. The stored word appears on `psw_o` after the next rising clock edge.
- R3: A 64-bit load (`load_long_i`=0) uses `load_data_i[0:63]`. Bits 0-32 are copied to the same positions, then bit 12 is cleared. Bits 33-63 of the stored word are set to zero. Image bits 33-63 become a 31-bit address, zero-extended into word bits 64-127.
- R4: An image is rejected in any of these cases: bit 12 is not 1 on a 64-bit load or not 0 on a 128-bit load; bits 31 and 32 are both 1; any of bits 0, 2, 3, 4 or 25-30 is 1; on a 128-bit load, any of bits 33-63 is 1. A rejected load leaves `psw_o` unchanged and raises `fmt_err_o` for exactly one cycle after the load edge.
- R5: Bits 31 and 32 select the addressing mode: 00 is 24-bit, 01 is 31-bit, 10 is 64-bit. Every address write keeps only the low 24, low 31 or all 64 bits, according to that mode.
- R6: A condition-code update (`cc_we_i`) writes `cc_i` into bits 18-19 and changes no other bit.
- R7: An address update (`ia_we_i`) writes bits 64-127 only, masked by the mode stored at that moment.
- R8: When `load_i` is high in a cycle, the condition-code and address updates of that cycle are ignored. This holds even when the load is rejected.
- R9: `br_taken_o` is 1 when the branch mask selects the stored condition code. Mask bit 3 (value 8) selects code 0, bit 2 selects code 1, bit 1 selects code 2 and bit 0 selects code 3.
- R10: The condition code stored in bits 18-19 is read as a 2-bit number, with bit 18 as its most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load request |
| load_long_i | input | 1 | 1: 128-bit image, 0: 64-bit image in bits 0-63 |
| load_data_i | input | 128 | Image to load, bit 0 most significant |
| cc_we_i | input | 1 | Condition-code write enable |
| cc_i | input | 2 | New condition code |
| ia_we_i | input | 1 | Instruction-address write enable |
| ia_i | input | 64 | New instruction address |
| br_mask_i | input | 4 | Branch condition mask |
| psw_o | output | 128 | Current status word |
| br_taken_o | output | 1 | Branch condition met |
| fmt_err_o | output | 1 | One-cycle pulse after a rejected load |

## Verification
The bench rejects images one fault at a time: a wrong marker in each direction, both mode bits set, a single must-be-zero bit set, and a stray bit in the reserved half of a 128-bit image. A design that checked only part of this would store a corrupt word. A design that stretched or dropped the error pulse would show up on the idle cycle after the error. Address masking is checked in all three modes, including updates made after the mode has changed, so a design that masked using the incoming bits or skipped the mask would leave high address bits set. Same-cycle load and update pairs, with both accepted and rejected loads, would expose wrong priority. Sweeping every mask against every stored code would catch a branch decoder whose bit order is reversed.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned IA_W    = 64;
  localparam int unsigned PSW_W   = 64 + IA_W;
  localparam int unsigned SHORT_W = 64;
  localparam int unsigned CC_W    = 2;
  localparam int unsigned MASK_W  = 1 << CC_W;

  // field positions (bit 0 = msb)
  localparam int unsigned FMT_BIT = 12;
  localparam int unsigned EA_BIT  = 31;
  localparam int unsigned BA_BIT  = 32;
  localparam int unsigned CC_HI   = 18;
  localparam int unsigned CC_LO   = 19;
  localparam int unsigned IA_HI   = PSW_W - IA_W;

  typedef logic [0:PSW_W-1] psw_t;

  typedef enum logic [1:0] {
    MODE_24  = 2'b00,
    MODE_31  = 2'b01,
    MODE_64  = 2'b10,
    MODE_BAD = 2'b11
  } amode_e;
endpackage

// File: rtl/psw_load_fmt.sv
module psw_load_fmt
  import psw_pkg::*;
(
  input  logic  is_long_i,
  input  psw_t  image_i,
  output logic  ok_o,
  output psw_t  word_o
);
  localparam int unsigned SIA_W = SHORT_W - BA_BIT - 1;

  logic zero_bits_ok;
  logic hole_ok;
  logic marker_ok;
  logic mode_ok;

  always_comb begin
    zero_bits_ok = !image_i[0] && (image_i[2:4] == '0) && (image_i[25:30] == '0);
    hole_ok      = !is_long_i || (image_i[BA_BIT+1:SHORT_W-1] == '0);
    marker_ok    = image_i[FMT_BIT] == !is_long_i;
    mode_ok      = !(image_i[EA_BIT] && image_i[BA_BIT]);
    ok_o         = zero_bits_ok && hole_ok && marker_ok && mode_ok;
  end

  always_comb begin
    if (is_long_i) begin
      word_o = image_i;
    end else begin
      word_o = '0;
      word_o[0:BA_BIT] = image_i[0:BA_BIT];
      word_o[FMT_BIT]  = 1'b0;
      word_o[PSW_W-SIA_W:PSW_W-1] = image_i[BA_BIT+1:SHORT_W-1];
    end
  end
endmodule

// File: rtl/psw_ia_mask.sv
module psw_ia_mask
  import psw_pkg::*;
(
  input  amode_e          mode_i,
  input  logic [IA_W-1:0] ia_i,
  output logic [IA_W-1:0] ia_o
);
  localparam int unsigned W24 = 24;
  localparam int unsigned W31 = 31;

  logic [IA_W-1:0] keep;

  always_comb begin
    unique case (mode_i)
      MODE_24: keep = {{(IA_W-W24){1'b0}}, {W24{1'b1}}};
      MODE_31: keep = {{(IA_W-W31){1'b0}}, {W31{1'b1}}};
      default: keep = '1;
    endcase
    ia_o = ia_i & keep;
  end
endmodule

// File: rtl/psw_branch.sv
module psw_branch
  import psw_pkg::*;
(
  input  logic [CC_W-1:0]   cc_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              taken_o
);
  logic [MASK_W-1:0] sel;

  // code 0 maps to the mask msb
  for (genvar g = 0; g < MASK_W; g++) begin : g_sel
    assign sel[MASK_W-1-g] = (cc_i == CC_W'(g));
  end

  assign taken_o = |(sel & mask_i);
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_long_i,
  input  logic [0:PSW_W-1]  load_data_i,
  input  logic              cc_we_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic              ia_we_i,
  input  logic [IA_W-1:0]   ia_i,
  input  logic [MASK_W-1:0] br_mask_i,
  output logic [0:PSW_W-1]  psw_o,
  output logic              br_taken_o,
  output logic              fmt_err_o
);
  psw_t            psw_q;
  psw_t            load_word;
  logic            load_ok;
  logic            fmt_err_q;
  logic [IA_W-1:0] load_ia_m;
  logic [IA_W-1:0] upd_ia_m;
  amode_e          load_mode;
  amode_e          cur_mode;

  psw_load_fmt u_fmt (
    .is_long_i (load_long_i),
    .image_i   (load_data_i),
    .ok_o      (load_ok),
    .word_o    (load_word)
  );

  assign load_mode = amode_e'({load_word[EA_BIT], load_word[BA_BIT]});
  assign cur_mode  = amode_e'({psw_q[EA_BIT], psw_q[BA_BIT]});

  psw_ia_mask u_mask_load (
    .mode_i (load_mode),
    .ia_i   (load_word[IA_HI:PSW_W-1]),
    .ia_o   (load_ia_m)
  );

  psw_ia_mask u_mask_upd (
    .mode_i (cur_mode),
    .ia_i   (ia_i),
    .ia_o   (upd_ia_m)
  );

  psw_branch u_br (
    .cc_i    (psw_q[CC_HI:CC_LO]),
    .mask_i  (br_mask_i),
    .taken_o (br_taken_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q     <= '0;
      fmt_err_q <= 1'b0;
    end else begin
      fmt_err_q <= load_i && !load_ok;
      if (load_i) begin
        if (load_ok) psw_q <= {load_word[0:IA_HI-1], load_ia_m};
      end else begin
        if (cc_we_i) psw_q[CC_HI:CC_LO] <= cc_i;
        if (ia_we_i) psw_q[IA_HI:PSW_W-1] <= upd_ia_m;
      end
    end
  end

  assign psw_o     = psw_q;
  assign fmt_err_o = fmt_err_q;

  assert_err_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> psw_q == $past(psw_q));
  assert_err_after_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> $past(load_i));
  assert_no_bad_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psw_q[EA_BIT] && psw_q[BA_BIT]));
  assert_ia24_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psw_q[EA_BIT] && !psw_q[BA_BIT]) |-> psw_q[IA_HI:PSW_W-25] == '0);
  assert_marker_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psw_q[FMT_BIT]);
  assert_cc_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_we_i && !load_i) |=> psw_q[CC_HI:CC_LO] == $past(cc_i));
  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !load_ok) |=> $stable(psw_q));
  assert_branch_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_mask_i == '1) |-> br_taken_o);
  assert_branch_none_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_mask_i == '0) |-> !br_taken_o);
endmodule

// File: tb/tb_psw_unit.sv
`timescale 1ns/1ps
module tb_psw_unit;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic          load_long = 1'b0;
  logic [0:127]  load_data = '0;
  logic          cc_we = 1'b0;
  logic [1:0]    cc = '0;
  logic          ia_we = 1'b0;
  logic [63:0]   ia = '0;
  logic [3:0]    br_mask = '0;
  logic [0:127]  psw;
  logic          br_taken;
  logic          fmt_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [0:127] exp_psw = '0;
  logic [0:127] q_psw[$];
  logic         q_err[$];
  string        q_req[$];

  always #2 clk = ~clk;

  psw_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_long_i(load_long),
    .load_data_i(load_data), .cc_we_i(cc_we), .cc_i(cc), .ia_we_i(ia_we),
    .ia_i(ia), .br_mask_i(br_mask), .psw_o(psw), .br_taken_o(br_taken),
    .fmt_err_o(fmt_err)
  );

  function automatic logic img_ok(logic lng, logic [0:127] d);
    logic ok;
    ok = (d[12] == !lng) && !(d[31] && d[32]) && !d[0] && (d[2:4] == 0) && (d[25:30] == 0);
    if (lng && d[33:63] != 0) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [63:0] mask_ia(logic ea, logic ba, logic [63:0] a);
    if (!ea && !ba) return a & 64'h0000_0000_00FF_FFFF;
    if (!ea && ba)  return a & 64'h0000_0000_7FFF_FFFF;
    return a;
  endfunction

  task automatic step(input logic ld, input logic lng, input logic [0:127] d,
                      input logic cwe, input logic [1:0] c,
                      input logic iwe, input logic [63:0] a, input string req);
    logic [0:127] w;
    logic err;
    @(negedge clk);
    load = ld; load_long = lng; load_data = d;
    cc_we = cwe; cc = c; ia_we = iwe; ia = a;
    err = 1'b0;
    if (ld) begin
      if (img_ok(lng, d)) begin
        if (lng) w = d;
        else begin
          w = '0;
          w[0:32] = d[0:32];
          w[12] = 1'b0;
          w[97:127] = d[33:63];
        end
        w[64:127] = mask_ia(w[31], w[32], w[64:127]);
        exp_psw = w;
      end else err = 1'b1;
    end else begin
      if (cwe) exp_psw[18:19] = c;
      if (iwe) exp_psw[64:127] = mask_ia(exp_psw[31], exp_psw[32], a);
    end
    q_psw.push_back(exp_psw);
    q_err.push_back(err);
    q_req.push_back(req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 1'b0, '0, 1'b0, 2'b00, 1'b0, '0, req);
  endtask

  // monitor: compare one expected item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_psw.size() > 0) begin
        logic [0:127] ep;
        logic ee;
        string r;
        ep = q_psw.pop_front();
        ee = q_err.pop_front();
        r  = q_req.pop_front();
        checks++;
        if (psw !== ep || fmt_err !== ee) begin
          failures++;
          $display("FAIL %s psw=%h err=%b expected psw=%h err=%b", r, psw, fmt_err, ep, ee);
        end
      end
    end
  end

  task automatic br_check(input logic [3:0] m);
    logic e;
    @(negedge clk);
    br_mask = m;
    #1;
    e = m[3 - exp_psw[18:19]];
    checks++;
    if (br_taken !== e) begin
      failures++;
      $display("FAIL R9/R10 mask=%b cc=%0d taken=%b expected %b", m, exp_psw[18:19], br_taken, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [0:127] img;
    repeat (3) @(negedge clk);
    checks++;
    if (psw !== '0 || fmt_err !== 1'b0) begin
      failures++;
      $display("FAIL R1 psw=%h err=%b expected psw=0 err=0", psw, fmt_err);
    end
    rst_n = 1'b1;

    // R2 R5: 128-bit, 64-bit mode
    img = '0; img[1] = 1; img[5:11] = 7'h5A; img[13:23] = 11'h5A5; img[31] = 1;
    img[64:127] = 64'hFEDC_BA98_7654_3210;
    step(1, 1, img, 0, 0, 0, 0, "R2_long64");
    // R2 R5: 31-bit mode masks high bits
    img[31] = 0; img[32] = 1;
    step(1, 1, img, 0, 0, 0, 0, "R5_long31");
    // R5: 24-bit mode
    img[32] = 0;
    step(1, 1, img, 0, 0, 0, 0, "R5_long24");
    // R3: 64-bit image, 31-bit mode
    img = '0; img[12] = 1; img[8:11] = 4'h9; img[18:19] = 2'b10; img[32] = 1;
    img[33:63] = 31'h7ABC_DEF1;
    step(1, 0, img, 0, 0, 0, 0, "R3_short31");
    // R3 R5: 64-bit image, 24-bit mode
    img[32] = 0;
    step(1, 0, img, 0, 0, 0, 0, "R3_short24");
    // R3: 64-bit image, 64-bit mode
    img[31] = 1;
    step(1, 0, img, 0, 0, 0, 0, "R3_short64");

    // R4 rejects, each followed by an idle cycle
    img = '0; img[31] = 1;
    step(1, 0, img, 0, 0, 0, 0, "R4_short_marker0"); idle("R4_pulse_end");
    img[12] = 1;
    step(1, 1, img, 0, 0, 0, 0, "R4_long_marker1"); idle("R4_pulse_end");
    img = '0; img[31] = 1; img[32] = 1;
    step(1, 1, img, 0, 0, 0, 0, "R4_bad_mode"); idle("R4_pulse_end");
    img = '0; img[27] = 1;
    step(1, 1, img, 0, 0, 0, 0, "R4_zero_bit27"); idle("R4_pulse_end");
    img = '0; img[12] = 1; img[3] = 1;
    step(1, 0, img, 0, 0, 0, 0, "R4_zero_bit3"); idle("R4_pulse_end");
    img = '0; img[40] = 1;
    step(1, 1, img, 0, 0, 0, 0, "R4_long_hole"); idle("R4_pulse_end");

    // R6 R7 in 64-bit mode
    step(0, 0, '0, 1, 2'b01, 0, 0, "R6_cc");
    step(0, 0, '0, 0, 2'b00, 1, 64'hA5A5_0000_1234_5678, "R7_ia64");
    step(0, 0, '0, 1, 2'b11, 1, 64'h0123_4567_89AB_CDEF, "R6_R7_both");
    // switch to 24-bit mode, then update address
    img = '0; img[12] = 1; img[33:63] = 31'h1;
    step(1, 0, img, 0, 0, 0, 0, "R3_to24");
    step(0, 0, '0, 0, 2'b00, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R7_ia24");
    // R8: accepted load with updates
    img = '0; img[32] = 1; img[18:19] = 2'b10; img[64:127] = 64'h8000_0000_0000_0042;
    step(1, 1, img, 1, 2'b01, 1, 64'h0000_0000_0000_0777, "R8_load_wins");
    // R8: rejected load with updates
    img[0] = 1;
    step(1, 1, img, 1, 2'b11, 1, 64'h0000_0000_0000_0999, "R8_bad_load_blocks");
    idle("R8_after");

    // R9 R10: sweep every code and mask
    for (int c = 0; c < 4; c++) begin
      step(0, 0, '0, 1, 2'(c), 0, 0, "R6_cc_sweep");
      idle("R6_hold");
      for (int m = 0; m < 16; m++) br_check(4'(m));
    end

    @(negedge clk);
    wait (q_psw.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule